// File: doc/BRIEF.md
# Glitch-Free Smart Card Clock Generator

This block produces the clock driven onto a smart card's clock contact. It has two independent sources: a crystal clock, divided by 2, 4 or 8, and a slower internal oscillator clock, divided by 2. A configuration word chooses the source and ratio. It also holds a park request with its level, a bypass that copies a software bit straight onto the contact for synchronous cards, and a doubling option for the clock handed to the card UART. The word is loaded with a one-cycle write strobe in the crystal domain.

Every change of ratio, source or park state finishes the half-period in progress before the new setting takes over. A source change is a handshake through two-flop synchronizers. The old source retires in its own domain while its output is low. The new source starts, also from low, only once it has seen that release. A busy flag is high from the write until the new setting drives the output. Software polls this flag before the next write.

Top module: `card_clk_gen`

## Requirements
- R1: With `src_sel_i[2]`=0 the card clock is the crystal divided by 2 for `src_sel_i[1:0]` = 00 or 01, by 4 for 10 and by 8 for 11.
- R2: With `src_sel_i[2]`=1 the card clock is the internal oscillator divided by 2, whatever `src_sel_i[1:0]` holds.
- R3: With `stop_i`=1 the card clock halts at `stop_lvl_i` (0 low, 1 high) once the running clock reaches that level, and stays there.
- R4: No high or low phase of the card clock is cut short across a ratio, source or park change. Every phase lasts at least the full half-period of the setting that produced it, and never less than one crystal period. At most one source drives the output at any time.
- R5: `busy_o` is 1 in the cycle after a write. It falls only when the written setting is in force on the output, and from then on the clock runs at exactly the new rate.
- R6: With `sync_mode_i`=1 the card clock and the UART clock equal `sync_bit_i` as written, one crystal cycle after the write.
- R7: With `dbl_i`=0 the UART clock equals the card clock. With `dbl_i`=1 it runs at twice the card clock frequency.
- R8: After reset the card clock is parked low, crystal/2 is selected, the bypass is off and `busy_o` is 0.
- R9: Leaving the parked state resumes from the parked level with a full half-period, and then the clock runs at the selected rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal_i | input | 1 | Crystal clock; also the configuration clock |
| clk_int_i | input | 1 | Internal oscillator clock, asynchronous to the crystal |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | One-cycle strobe loading the configuration word |
| src_sel_i | input | 3 | Source and ratio code (see R1, R2) |
| stop_i | input | 1 | Park request |
| stop_lvl_i | input | 1 | Park level |
| sync_mode_i | input | 1 | Synchronous-card bypass enable |
| sync_bit_i | input | 1 | Bypass value for the card clock |
| dbl_i | input | 1 | UART clock doubling enable |
| card_clk_o | output | 1 | Clock to the card contact |
| uart_clk_o | output | 1 | Clock to the card UART |
| busy_o | output | 1 | Change pending |

## Verification
The bench moves between all three crystal ratios and the internal source in both directions, and changes only the ignored ratio bits while the internal source runs. A runt at the handover would show as an edge closer than one crystal period. A leaked ratio bit would give a half-period other than 13 ns. It parks high and low and then restarts. A design that cuts the phase short on parking, or restarts mid-phase, would give a short pulse or the wrong parked level. It also checks that busy clears only when the measured half-periods already match the new setting, that the doubled UART clock has exactly half the card half-period at every ratio, and that the bypass copies the written bit on the next cycle.

// File: rtl/cclk_pkg.sv
package cclk_pkg;
  localparam int HLEN_W = 3;

  typedef struct packed {
    logic [2:0] sel;
    logic       stop;
    logic       lvl;
    logic       sync;
    logic       sc;
    logic       dbl;
  } cclk_cfg_t;

  // reset: parked low, crystal/2, bypass off
  localparam cclk_cfg_t CFG_RST = '{sel: 3'b000, stop: 1'b1, lvl: 1'b0,
                                    sync: 1'b0, sc: 1'b0, dbl: 1'b0};

  // half-period in source cycles for the crystal ratios
  function automatic logic [HLEN_W-1:0] xtal_half(input logic [1:0] ratio);
    case (ratio)
      2'b10:   return HLEN_W'(2);
      2'b11:   return HLEN_W'(4);
      default: return HLEN_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/cclk_sync.sv
module cclk_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cclk_div.sv
module cclk_div #(
  parameter int HLEN_W  = cclk_pkg::HLEN_W,
  parameter bit PROG    = 1'b1,
  parameter bit OWN_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              peer_en_i,
  input  logic              stop_i,
  input  logic              lvl_i,
  input  logic [HLEN_W-1:0] hlen_i,
  output logic              clk_o,
  output logic              dbl_o,
  output logic              en_o,
  output logic              settled_o
);
  logic [HLEN_W-1:0] cnt_q, cur_q;
  logic              ph_q, en_q;
  logic              frozen, half_end;

  assign frozen   = stop_i && (ph_q == lvl_i);
  assign half_end = (cnt_q == cur_q - HLEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= OWN_RST;
      ph_q  <= 1'b0;
      cnt_q <= '0;
      cur_q <= HLEN_W'(1);
    end else if (!en_q) begin
      cnt_q <= '0;
      cur_q <= hlen_i;
      if (req_i && !peer_en_i) en_q <= 1'b1;   // start from low
    end else if (frozen) begin
      cnt_q <= '0;
      cur_q <= hlen_i;
      if (!req_i && !ph_q) en_q <= 1'b0;       // parked high holds ownership
    end else if (half_end) begin
      cnt_q <= '0;
      cur_q <= hlen_i;                         // ratio only changes on a phase boundary
      if (!req_i) begin
        en_q <= 1'b0;
        ph_q <= 1'b0;
      end else begin
        ph_q <= ~ph_q;
      end
    end else begin
      cnt_q <= cnt_q + HLEN_W'(1);
    end
  end

  assign clk_o     = ph_q;
  assign en_o      = en_q;
  assign settled_o = (en_q == req_i) &&
                     (!en_q || ((!stop_i || ph_q == lvl_i) && cur_q == hlen_i));

  // doubled clock: xor with a copy delayed by half a phase
  logic d_neg_q;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_neg_q <= 1'b0;
    else         d_neg_q <= ph_q;
  end

  generate
    if (PROG) begin : g_prog
      logic d1_q, d2_q, dly;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          d1_q <= 1'b0;
          d2_q <= 1'b0;
        end else begin
          d1_q <= ph_q;
          d2_q <= d1_q;
        end
      end
      always_comb begin
        if (cur_q == HLEN_W'(1))      dly = d_neg_q;
        else if (cur_q == HLEN_W'(2)) dly = d1_q;
        else                          dly = d2_q;
      end
      assign dbl_o = ph_q ^ dly;
    end else begin : g_fixed
      assign dbl_o = ph_q ^ d_neg_q;
    end
  endgenerate

  // streak length of the previous output value
  logic              ph_d_q;
  logic [HLEN_W:0]   run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_d_q <= 1'b0;
      run_q  <= (HLEN_W+1)'(1);
    end else begin
      ph_d_q <= ph_q;
      if (ph_q != ph_d_q)  run_q <= (HLEN_W+1)'(1);
      else if (~&run_q)    run_q <= run_q + (HLEN_W+1)'(1);
    end
  end

  // R4
  full_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != ph_d_q) |-> (run_q >= {1'b0, $past(cur_q)}));

  // R3
  park_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && stop_i && ph_q == lvl_i) |=> (ph_q == $past(ph_q)));
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_xtal_i,
  input  logic       clk_int_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] src_sel_i,
  input  logic       stop_i,
  input  logic       stop_lvl_i,
  input  logic       sync_mode_i,
  input  logic       sync_bit_i,
  input  logic       dbl_i,
  output logic       card_clk_o,
  output logic       uart_clk_o,
  output logic       busy_o
);
  import cclk_pkg::*;
  localparam int HW = cclk_pkg::HLEN_W;

  cclk_cfg_t cfg_q;
  logic      tok_q;

  always_ff @(posedge clk_xtal_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
      tok_q <= 1'b0;
    end else if (wr_i) begin
      cfg_q <= '{sel: src_sel_i, stop: stop_i, lvl: stop_lvl_i,
                 sync: sync_mode_i, sc: sync_bit_i, dbl: dbl_i};
      tok_q <= ~tok_q;
    end
  end

  // crystal domain
  logic x_clk, x_dbl, x_en, x_settled, x_peer, ack_x;

  cclk_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync_peer_x (
    .clk_i(clk_xtal_i), .rst_ni(rst_ni), .d_i(i_en), .q_o(x_peer));

  cclk_div #(.HLEN_W(HW), .PROG(1'b1), .OWN_RST(1'b1)) i_div_x (
    .clk_i(clk_xtal_i), .rst_ni(rst_ni), .req_i(~cfg_q.sel[2]),
    .peer_en_i(x_peer), .stop_i(cfg_q.stop), .lvl_i(cfg_q.lvl),
    .hlen_i(xtal_half(cfg_q.sel[1:0])), .clk_o(x_clk), .dbl_o(x_dbl),
    .en_o(x_en), .settled_o(x_settled));

  // internal oscillator domain
  logic       i_clk, i_dbl, i_en, i_settled, i_peer;
  logic       i_req, i_stop, i_lvl, i_tok, ack_i_q;
  logic [3:0] i_bus;

  cclk_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync_cfg_i (
    .clk_i(clk_int_i), .rst_ni(rst_ni),
    .d_i({cfg_q.sel[2], cfg_q.stop, cfg_q.lvl, tok_q}), .q_o(i_bus));
  assign {i_req, i_stop, i_lvl, i_tok} = i_bus;

  cclk_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync_peer_i (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .d_i(x_en), .q_o(i_peer));

  cclk_div #(.HLEN_W(HW), .PROG(1'b0), .OWN_RST(1'b0)) i_div_i (
    .clk_i(clk_int_i), .rst_ni(rst_ni), .req_i(i_req),
    .peer_en_i(i_peer), .stop_i(i_stop), .lvl_i(i_lvl),
    .hlen_i(HW'(1)), .clk_o(i_clk), .dbl_o(i_dbl),
    .en_o(i_en), .settled_o(i_settled));

  // echo the write token once this domain has taken the new setting
  always_ff @(posedge clk_int_i or negedge rst_ni) begin
    if (!rst_ni)        ack_i_q <= 1'b0;
    else if (i_settled) ack_i_q <= i_tok;
  end

  cclk_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync_ack (
    .clk_i(clk_xtal_i), .rst_ni(rst_ni), .d_i(ack_i_q), .q_o(ack_x));

  assign busy_o = (ack_x != tok_q) || !x_settled;

  logic mux_clk;
  assign mux_clk    = x_clk | i_clk;
  assign card_clk_o = cfg_q.sync ? cfg_q.sc : mux_clk;
  assign uart_clk_o = cfg_q.sync ? cfg_q.sc : (cfg_q.dbl ? (x_dbl | i_dbl) : mux_clk);

  // R4
  single_owner_chk: assert property (@(posedge clk_xtal_i) disable iff (!rst_ni)
    !(x_en && i_en));

  // R5
  busy_on_write_chk: assert property (@(posedge clk_xtal_i) disable iff (!rst_ni)
    wr_i |=> busy_o);

  // R6
  sync_copy_chk: assert property (@(posedge clk_xtal_i) disable iff (!rst_ni)
    (wr_i && sync_mode_i) |=> (card_clk_o == $past(sync_bit_i)));
endmodule

// File: tb/test_card_clk_gen.sv
`timescale 1ns/1ps
module test_card_clk_gen;
  logic clk_x = 1'b0, clk_i = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [2:0] sel = 3'b000;
  logic stop = 1'b1, lvl = 1'b0, syn = 1'b0, sc = 1'b0, dbl = 1'b0;
  logic card, uart, busy;

  always #2.5 clk_x = ~clk_x;   // 200 MHz crystal
  always #6.5 clk_i = ~clk_i;   // internal oscillator, 13 ns period

  card_clk_gen i_card_clk_gen (
    .clk_xtal_i(clk_x), .clk_int_i(clk_i), .rst_ni(rst_n), .wr_i(wr),
    .src_sel_i(sel), .stop_i(stop), .stop_lvl_i(lvl), .sync_mode_i(syn),
    .sync_bit_i(sc), .dbl_i(dbl), .card_clk_o(card), .uart_clk_o(uart),
    .busy_o(busy));

  int  n_run = 0, n_fail = 0, runt_cnt = 0;
  bit  done = 1'b0, mon_on = 1'b0;
  realtime last_edge = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  // reference: expected half-period in ns from the selection code
  function automatic real half_ns(input logic [2:0] s);
    if (s[2])               return 13.0;
    else if (s[1:0] == 2'b10) return 10.0;
    else if (s[1:0] == 2'b11) return 20.0;
    else                    return 5.0;
  endfunction

  // R4: no phase shorter than one crystal period, watched on every edge
  always @(card) begin
    if (mon_on && ($realtime - last_edge) < 4.9) begin
      runt_cnt++;
      $display("FAIL R4 runt phase: actual %0.3f expected >= 5.000",
               $realtime - last_edge);
    end
    last_edge = $realtime;
  end

  task automatic wr_cfg(input logic [2:0] s, input logic st, input logic lv,
                        input logic sy, input logic scb, input logic db);
    @(negedge clk_x);
    sel = s; stop = st; lvl = lv; syn = sy; sc = scb; dbl = db; wr = 1'b1;
    @(negedge clk_x);
    wr = 1'b0;
    check(busy === 1'b1, "R5", "busy after write", real'(busy), 1.0);
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy !== 1'b0 && k < 3000) begin
      @(negedge clk_x);
      k++;
    end
    check(busy === 1'b0, "R5", "busy cleared", real'(busy), 0.0);
  endtask

  task automatic meas(input bit on_uart, input real exp, input string req);
    realtime t0, t;
    real worst = exp;
    real d;
    bit ok = 1'b1;
    if (on_uart) @(uart); else @(card);
    t0 = $realtime;
    for (int k = 0; k < 8; k++) begin
      if (on_uart) @(uart); else @(card);
      t = $realtime;
      d = (t - t0) - exp;
      if (d > 0.05 || d < -0.05) begin
        ok = 1'b0;
        worst = t - t0;
      end
      t0 = t;
    end
    check(ok, req, on_uart ? "uart half-period ns" : "card half-period ns", worst, exp);
  endtask

  task automatic hold(input logic level, input int cycles, input string req);
    bit ok = 1'b1;
    logic seen = level;
    repeat (cycles) begin
      @(negedge clk_x);
      if (card !== level) begin
        ok = 1'b0;
        seen = card;
      end
    end
    check(ok, req, "parked level", real'(seen), real'(level));
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk_x);
    rst_n = 1'b1;
    last_edge = $realtime;
    mon_on = 1'b1;

    // R8 reset state
    hold(1'b0, 20, "R8");
    check(busy === 1'b0, "R8", "busy after reset", real'(busy), 0.0);
    check(uart === 1'b0, "R8", "uart after reset", real'(uart), 0.0);

    // R1 crystal ratios, R7 undoubled uart
    wr_cfg(3'b000, 0, 0, 0, 0, 0); wait_idle();
    meas(0, half_ns(3'b000), "R1");
    meas(1, half_ns(3'b000), "R7");
    wr_cfg(3'b010, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b010), "R1");
    wr_cfg(3'b011, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b011), "R1");
    wr_cfg(3'b001, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b001), "R1");

    // R2 internal source, low bits ignored
    wr_cfg(3'b101, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b101), "R2");
    wr_cfg(3'b110, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b110), "R2");
    wr_cfg(3'b011, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b011), "R1");

    // R7 doubled uart clock
    wr_cfg(3'b011, 0, 0, 0, 0, 1); wait_idle(); meas(1, half_ns(3'b011) / 2.0, "R7");
    wr_cfg(3'b000, 0, 0, 0, 0, 1); wait_idle(); meas(1, half_ns(3'b000) / 2.0, "R7");
    wr_cfg(3'b100, 0, 0, 0, 0, 1); wait_idle(); meas(1, half_ns(3'b100) / 2.0, "R7");
    meas(0, half_ns(3'b100), "R2");

    // R3 park high, R9 restart, R3 park low
    wr_cfg(3'b010, 0, 0, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b010), "R1");
    wr_cfg(3'b010, 1, 1, 0, 0, 0); wait_idle(); hold(1'b1, 60, "R3");
    wr_cfg(3'b010, 0, 1, 0, 0, 0); wait_idle(); meas(0, half_ns(3'b010), "R9");
    wr_cfg(3'b010, 1, 0, 0, 0, 0); wait_idle(); hold(1'b0, 60, "R3");

    // R6 synchronous bypass
    wr_cfg(3'b010, 1, 0, 1, 1, 0);
    check(card === 1'b1, "R6", "card copies bit 1", real'(card), 1.0);
    check(uart === 1'b1, "R6", "uart copies bit 1", real'(uart), 1.0);
    wait_idle();
    wr_cfg(3'b010, 1, 0, 1, 0, 0);
    check(card === 1'b0, "R6", "card copies bit 0", real'(card), 0.0);
    wait_idle();
    wr_cfg(3'b010, 1, 0, 0, 0, 0); wait_idle();
    hold(1'b0, 20, "R6");

    check(runt_cnt == 0, "R4", "runt phases seen", real'(runt_cnt), 0.0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R5 watchdog expired: actual 1 expected 0");
      summary();
      $finish;
    end
  end
endmodule